// File: doc/BRIEF.md
# Receive Queue with Trigger Level and Character Timeout

This block holds the bytes a serial receiver has assembled until the host collects them. It can run as a 16-entry first-in first-out queue or as a single holding byte. One control-byte write chooses the mode, and the same write sets the host's interrupt threshold (the trigger level), empties the queue on request and marks when the transmit queue beside it must be flushed. The block also reports the data-ready, break and overrun status bits.

A character-time counter runs on a bit-period tick. The length of one character comes from the line configuration, and the timeout window is four characters long. If bytes wait in the queue and the host neither reads nor receives anything for that window, the block raises a timeout-pending flag. The interrupt arbiter and the deserializer are separate blocks.

Top module: `rxq_trig_timeout`

## Requirements
- R1: After reset the queue is disabled and empty. Data ready, break, overrun and timeout pending are all 0, the trigger level reads 1 and the DMA-mode bit is 0.
- R2: With the queue enabled, bytes come back on `rd_data` in arrival order, across any wrap of the storage. `rx_level` equals the number of bytes held.
- R3: Control bits [7:6] set the trigger level: code 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 (for depth 16).
- R4: Control bit 0 (queue enable), bit 3 (DMA mode) and bits [7:6] are stored. Bit 1 (receive clear) and bit 2 (transmit flush, shown on `tx_flush` during the write cycle) act only once.
- R5: A control write that changes the enable bit clears the receive queue and raises `tx_flush` in that write cycle. A write that keeps the enable bit, with bits 1 and 2 at 0, leaves the stored bytes in place.
- R6: A receive clear empties the queue, clears data ready, break and timeout pending, and stops the timeout counter.
- R7: The character length in bits is (cfg[1:0]+5), plus 1 when cfg[3] is set, plus 2 stop bits when cfg[2] is set or 1 otherwise. Timeout pending rises on the 4×length-th bit tick after the last restart, provided the queue is not empty.
- R8: A host read clears timeout pending. A read that leaves the queue empty clears data ready and break. A read that leaves bytes behind restarts the timeout window.
- R9: With the queue disabled, one holding byte is used. A read clears data ready and break, and `rx_level` shows data ready as 0 or 1.
- R10: A received break stores a zero byte and sets both break and data ready. A line-status read (`lsr_rd`) clears break.
- R11: A byte that arrives while storage is full (16 bytes, or a holding byte not yet read) is discarded and sets overrun. Overrun stays set until `lsr_rd`.
- R12: If the timeout window ends while the queue is empty, timeout pending stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| brk_valid | input | 1 | One-cycle strobe for a received break |
| rd_strobe | input | 1 | Host read of the receive buffer |
| lsr_rd | input | 1 | Host read of line status (clears break and overrun) |
| fcr_we | input | 1 | Control-byte write strobe |
| fcr_wdata | input | 8 | Control byte |
| line_cfg | input | 4 | Line configuration: [1:0] data length, [2] two stop bits, [3] parity on |
| bit_tick | input | 1 | One pulse per bit period |
| rd_data | output | 8 | Byte that a read in this cycle returns |
| data_ready | output | 1 | Received data available |
| break_flag | output | 1 | Break received |
| overrun_flag | output | 1 | A byte was discarded |
| rx_level | output | 5 | Bytes held |
| trig_level | output | 5 | Trigger level in bytes |
| fifo_en | output | 1 | Queue mode enabled |
| dma_mode | output | 1 | Stored DMA-mode bit |
| tx_flush | output | 1 | Transmit-queue flush request, valid in the write cycle |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The bench sweeps all sixteen line configurations. For each one it checks that the timeout flag is still low one tick before the computed window ends and high on the last tick, so a design that is off by one tick or that drops the parity or stop-bit term fails. Rounds of different lengths push the pointers across the wrap point. These catch a design that loses order at the wrap, and one that overwrites the oldest byte on overflow when it should discard the new byte. Other cases check that a read leaving bytes behind restarts the window, that an expiry on an empty queue is ignored, and that a control write keeping the enable bit does not flush the stored data.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      TRIG_ONE  = 2'b00,
      TRIG_QTR  = 2'b01,
      TRIG_HALF = 2'b10,
      TRIG_HIGH = 2'b11
   } trig_code_e;

   localparam int unsigned FRAME_W = 4;

   // bits per character: data length, optional parity, one or two stop bits
   function automatic logic [FRAME_W-1:0] frame_bits(input logic [3:0] cfg);
      logic [FRAME_W-1:0] n;
      n = 4'd5 + {2'b00, cfg[1:0]};
      n = n + {3'b000, cfg[3]};
      n = n + (cfg[2] ? 4'd2 : 4'd1);
      return n;
   endfunction

endpackage

// File: rtl/rxq_fcr_ctl.sv
module rxq_fcr_ctl
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       wdata,
   output logic             en,
   output logic             dma,
   output logic [CNT_W-1:0] lvl,
   output logic             rx_clear,
   output logic             tx_flush
);

   localparam int unsigned LVL_QTR  = DEPTH / 4;
   localparam int unsigned LVL_HALF = DEPTH / 2;
   localparam int unsigned LVL_HIGH = DEPTH - 2;

   generate
      if (DEPTH < 8) begin : g_bad_depth
         $error("rxq_fcr_ctl: DEPTH must be at least 8");
      end
   endgenerate

   logic       en_q;
   logic       dma_q;
   trig_code_e code_q;
   logic       toggle;
   wire        unused_bits = ^wdata[5:4];

   assign toggle   = we && (wdata[0] != en_q);
   assign rx_clear = we && (wdata[1] || toggle);
   assign tx_flush = we && (wdata[2] || toggle);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         dma_q  <= 1'b0;
         code_q <= TRIG_ONE;
      end else if (we) begin
         en_q   <= wdata[0];
         dma_q  <= wdata[3];
         code_q <= trig_code_e'(wdata[7:6]);
      end
   end

   always_comb begin
      case (code_q)
         TRIG_ONE:  lvl = CNT_W'(1);
         TRIG_QTR:  lvl = CNT_W'(LVL_QTR);
         TRIG_HALF: lvl = CNT_W'(LVL_HALF);
         default:   lvl = CNT_W'(LVL_HIGH);
      endcase
   end

   assign en  = en_q;
   assign dma = dma_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] front,
   output logic [CNT_W-1:0]  count,
   output logic              full
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          POW2  = ((1 << PTR_W) == DEPTH);

   generate
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("rxq_store: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_p, rd_p, wr_nx, rd_nx;
   logic [CNT_W-1:0]  cnt;
   logic              do_pop, do_push;

   assign full    = (cnt == CNT_W'(DEPTH));
   assign do_pop  = pop && (cnt != '0) && !clear;
   assign do_push = push && (!full || do_pop) && !clear;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nx = wr_p + 1'b1;
         assign rd_nx = rd_p + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nx = (wr_p == PTR_W'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
         assign rd_nx = (rd_p == PTR_W'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_p] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_p <= '0;
         rd_p <= '0;
         cnt  <= '0;
      end else if (clear) begin
         wr_p <= '0;
         rd_p <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wr_p <= wr_nx;
         if (do_pop)  rd_p <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign front = (cnt == '0) ? '0 : mem[rd_p];
   assign count = cnt;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clear) |=> (count == CNT_W'(DEPTH))); // R11
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0)); // R6

endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer
   import rxq_pkg::*;
#(
   parameter int unsigned TO_CHARS = 4,
   parameter int unsigned LIM_W    = 6
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               cancel,
   input  logic               tick,
   input  logic [FRAME_W-1:0] char_len,
   output logic               expire
);

   generate
      if (TO_CHARS < 1) begin : g_bad_chars
         $error("rxq_char_timer: TO_CHARS must be positive");
      end
   endgenerate

   logic             armed;
   logic [LIM_W-1:0] cnt;
   logic [LIM_W-1:0] limit;

   assign limit  = LIM_W'(TO_CHARS) * LIM_W'(char_len);
   assign expire = armed && tick && !restart && !cancel && (cnt >= limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (cancel) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (restart) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (armed && tick) begin
         if (expire) armed <= 1'b0;
         else        cnt   <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rxq_trig_timeout.sv
module rxq_trig_timeout
   import rxq_pkg::*;
#(
   parameter  int unsigned DEPTH    = 16,
   parameter  int unsigned DATA_W   = 8,
   parameter  int unsigned TO_CHARS = 4,
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
   localparam int unsigned LIM_W    = $clog2(TO_CHARS * 12 + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              brk_valid,
   input  logic              rd_strobe,
   input  logic              lsr_rd,
   input  logic              fcr_we,
   input  logic [7:0]        fcr_wdata,
   input  logic [3:0]        line_cfg,
   input  logic              bit_tick,
   output logic [DATA_W-1:0] rd_data,
   output logic              data_ready,
   output logic              break_flag,
   output logic              overrun_flag,
   output logic [CNT_W-1:0]  rx_level,
   output logic [CNT_W-1:0]  trig_level,
   output logic              fifo_en,
   output logic              dma_mode,
   output logic              tx_flush,
   output logic              timeout_pend
);

   logic              rx_clear;
   logic              in_valid;
   logic [DATA_W-1:0] in_byte;
   logic              q_push, q_pop, q_full;
   logic [DATA_W-1:0] q_front;
   logic [CNT_W-1:0]  q_count;
   logic              pop_real, leaves_empty, leaves_bytes;
   logic              hold_push, hold_accept;
   logic [DATA_W-1:0] hold_q;
   logic              dr_q, brk_q, ovr_q, to_q;
   logic              dr_clr, ovr_set;
   logic              t_restart, t_expire;

   rxq_fcr_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fcr (
      .clk(clk), .rst_n(rst_n), .we(fcr_we), .wdata(fcr_wdata),
      .en(fifo_en), .dma(dma_mode), .lvl(trig_level),
      .rx_clear(rx_clear), .tx_flush(tx_flush)
   );

   assign in_valid = rx_valid || brk_valid;
   assign in_byte  = brk_valid ? '0 : rx_data;
   assign q_push   = fifo_en && in_valid && !rx_clear;
   assign q_pop    = fifo_en && rd_strobe && !rx_clear;

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(rx_clear),
      .push(q_push), .push_data(in_byte), .pop(q_pop),
      .front(q_front), .count(q_count), .full(q_full)
   );

   assign pop_real     = q_pop && (q_count != '0);
   assign leaves_empty = q_pop && !q_push && (q_count <= CNT_W'(1));
   assign leaves_bytes = pop_real && !leaves_empty;

   // single holding byte when the queue is off
   assign hold_push   = !fifo_en && in_valid && !rx_clear;
   assign hold_accept = hold_push && (!dr_q || rd_strobe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold_q <= '0;
      else if (hold_accept) hold_q <= in_byte;
   end

   assign dr_clr  = fifo_en ? leaves_empty : (rd_strobe && !hold_accept);
   assign ovr_set = (q_push && q_full && !pop_real) ||
                    (hold_push && dr_q && !rd_strobe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dr_q  <= 1'b0;
         brk_q <= 1'b0;
      end else if (rx_clear) begin
         dr_q  <= 1'b0;
         brk_q <= 1'b0;
      end else begin
         if (q_push || hold_accept) dr_q <= 1'b1;
         else if (dr_clr)           dr_q <= 1'b0;
         if (brk_valid)                brk_q <= 1'b1;
         else if (lsr_rd || dr_clr)    brk_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (ovr_set) ovr_q <= 1'b1;
      else if (lsr_rd)  ovr_q <= 1'b0;
   end

   assign t_restart = q_push || leaves_bytes;

   rxq_char_timer #(.TO_CHARS(TO_CHARS), .LIM_W(LIM_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(t_restart), .cancel(rx_clear),
      .tick(bit_tick), .char_len(frame_bits(line_cfg)), .expire(t_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  to_q <= 1'b0;
      else if (rx_clear)           to_q <= 1'b0;
      else if (rd_strobe)          to_q <= 1'b0;
      else if (t_expire && fifo_en && (q_count != '0)) to_q <= 1'b1;
   end

   assign rd_data      = fifo_en ? q_front : hold_q;
   assign data_ready   = dr_q;
   assign break_flag   = brk_q;
   assign overrun_flag = ovr_q;
   assign timeout_pend = to_q;
   assign rx_level     = fifo_en ? q_count : CNT_W'(dr_q);

   AST_TOGGLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (fcr_we && (fcr_wdata[0] != fifo_en)) |=> (rx_level == '0)); // R5
   AST_CFG_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_we |=> (fifo_en == $past(fcr_wdata[0]) && dma_mode == $past(fcr_wdata[3]))); // R4
   AST_TO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_pend) |-> (rx_level != '0)); // R7
   AST_READ_CLR_TO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> !timeout_pend); // R8
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && rd_strobe && rx_level == CNT_W'(1) && !rx_valid && !brk_valid && !fcr_we)
      |=> (!data_ready && !break_flag)); // R8
   AST_BRK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_valid && !fcr_we) |=> (data_ready && break_flag)); // R10
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && data_ready && rx_valid && !brk_valid && !rd_strobe && !fcr_we)
      |=> ($stable(rd_data) && overrun_flag)); // R11

endmodule

// File: tb/rxq_trig_timeout_tb_top.sv
`timescale 1ns/1ps
module rxq_trig_timeout_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       brk_valid = 1'b0;
   logic       rd_strobe = 1'b0;
   logic       lsr_rd = 1'b0;
   logic       fcr_we = 1'b0;
   logic [7:0] fcr_wdata = '0;
   logic [3:0] line_cfg = '0;
   logic       bit_tick = 1'b0;
   logic [7:0] rd_data;
   logic       data_ready, break_flag, overrun_flag, fifo_en, dma_mode, tx_flush, timeout_pend;
   logic [4:0] rx_level, trig_level;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   rxq_trig_timeout dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .brk_valid(brk_valid), .rd_strobe(rd_strobe), .lsr_rd(lsr_rd),
      .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .line_cfg(line_cfg),
      .bit_tick(bit_tick), .rd_data(rd_data), .data_ready(data_ready),
      .break_flag(break_flag), .overrun_flag(overrun_flag), .rx_level(rx_level),
      .trig_level(trig_level), .fifo_en(fifo_en), .dma_mode(dma_mode),
      .tx_flush(tx_flush), .timeout_pend(timeout_pend)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic fcr_wr(input logic [7:0] v, input int exp_flush, input string req);
      fcr_we = 1'b1; fcr_wdata = v;
      #1 chk(req, int'(tx_flush), exp_flush);
      cyc();
      fcr_we = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      rx_valid = 1'b1; rx_data = b;
      cyc();
      rx_valid = 1'b0;
   endtask

   task automatic brk();
      brk_valid = 1'b1;
      cyc();
      brk_valid = 1'b0;
   endtask

   task automatic pop(output int b);
      b = int'(rd_data);
      rd_strobe = 1'b1;
      cyc();
      rd_strobe = 1'b0;
   endtask

   task automatic lsr();
      lsr_rd = 1'b1;
      cyc();
      lsr_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1;
         cyc();
      end
      bit_tick = 1'b0;
   endtask

   function automatic int win(input int cfg);
      int n;
      n = 5 + (cfg & 3) + ((cfg >> 3) & 1) + (((cfg >> 2) & 1) ? 2 : 1);
      return 4 * n;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog all-reqs act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v;
      int lens[3];
      int nxt;
      lens[0] = 16; lens[1] = 7; lens[2] = 13;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset values
      chk("R1 fifo_en", int'(fifo_en), 0);
      chk("R1 level", int'(rx_level), 0);
      chk("R1 dr", int'(data_ready), 0);
      chk("R1 brk", int'(break_flag), 0);
      chk("R1 ovr", int'(overrun_flag), 0);
      chk("R1 to", int'(timeout_pend), 0);
      chk("R1 trig", int'(trig_level), 1);
      chk("R1 dma", int'(dma_mode), 0);

      // R3 / R4 trigger codes with enable and dma kept
      for (int c = 0; c < 4; c++) begin
         fcr_wr(8'((c << 6) | 9), (c == 0) ? 1 : 0, "R5 flush on toggle");
         chk("R3 trig", int'(trig_level), (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14);
         chk("R4 en", int'(fifo_en), 1);
         chk("R4 dma", int'(dma_mode), 1);
      end
      fcr_wr(8'h01, 0, "R4 no flush");
      chk("R4 dma off", int'(dma_mode), 0);

      // R2 order across wraps
      nxt = 0;
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < lens[r]; i++) push(8'((r * 37 + i * 5 + 1) & 255));
         chk("R2 level", int'(rx_level), lens[r]);
         for (int i = 0; i < lens[r]; i++) begin
            pop(v);
            chk("R2 order", v, (r * 37 + i * 5 + 1) & 255);
         end
         chk("R2 empty", int'(rx_level), 0);
         nxt += lens[r];
      end

      // R11 full discards the newest byte
      for (int i = 0; i < 16; i++) push(8'(i + 100));
      push(8'hEE);
      chk("R11 level", int'(rx_level), 16);
      chk("R11 ovr", int'(overrun_flag), 1);
      for (int i = 0; i < 16; i++) begin
         pop(v);
         chk("R11 kept", v, i + 100);
      end
      chk("R11 ovr held", int'(overrun_flag), 1);
      chk("R8 dr after drain", int'(data_ready), 0);
      lsr();
      chk("R11 ovr cleared", int'(overrun_flag), 0);

      // R7 window sweep over all line configs
      for (int cfg = 0; cfg < 16; cfg++) begin
         line_cfg = 4'(cfg);
         fcr_wr(8'h03, 0, "R6 no tx flush");
         push(8'h42);
         ticks(win(cfg) - 1);
         chk("R7 before window", int'(timeout_pend), 0);
         ticks(1);
         chk("R7 at window", int'(timeout_pend), 1);
         pop(v);
         chk("R8 read clears to", int'(timeout_pend), 0);
      end

      // R8 non-emptying read restarts window
      line_cfg = 4'h0;
      push(8'h01); push(8'h02);
      ticks(20);
      pop(v);
      chk("R8 dr kept", int'(data_ready), 1);
      ticks(23);
      chk("R8 restarted", int'(timeout_pend), 0);
      ticks(1);
      chk("R8 expiry after restart", int'(timeout_pend), 1);
      pop(v);
      chk("R8 last byte", v, 2);
      chk("R8 dr clr", int'(data_ready), 0);

      // R12 expiry on empty queue
      push(8'h07);
      pop(v);
      ticks(30);
      chk("R12 no timeout when empty", int'(timeout_pend), 0);

      // R6 receive clear
      push(8'h0A); push(8'h0B); push(8'h0C);
      ticks(24);
      chk("R6 setup to", int'(timeout_pend), 1);
      fcr_wr(8'h03, 0, "R6 no tx flush");
      chk("R6 level", int'(rx_level), 0);
      chk("R6 dr", int'(data_ready), 0);
      chk("R6 to", int'(timeout_pend), 0);

      // R4 tx flush one-shot, R5 same enable keeps data
      push(8'h21); push(8'h22);
      fcr_wr(8'h05, 1, "R4 tx flush bit");
      chk("R4 rx kept", int'(rx_level), 2);
      fcr_wr(8'hC1, 0, "R5 no flush");
      chk("R5 data kept", int'(rx_level), 2);
      chk("R5 front", int'(rd_data), 8'h21);

      // R10 break in queue mode
      brk();
      chk("R10 level", int'(rx_level), 3);
      chk("R10 brk", int'(break_flag), 1);
      pop(v); pop(v);
      chk("R10 brk kept", int'(break_flag), 1);
      pop(v);
      chk("R10 zero byte", v, 0);
      chk("R8 brk cleared by emptying", int'(break_flag), 0);

      // R5 disable toggle flushes
      push(8'h33);
      fcr_wr(8'h00, 1, "R5 flush on disable");
      chk("R5 emptied", int'(rx_level), 0);
      chk("R5 dr", int'(data_ready), 0);

      // R9 holding mode
      push(8'h5A);
      chk("R9 dr", int'(data_ready), 1);
      chk("R9 level", int'(rx_level), 1);
      chk("R9 data", int'(rd_data), 8'h5A);
      push(8'h33);
      chk("R11 hold discard", int'(rd_data), 8'h5A);
      chk("R11 hold ovr", int'(overrun_flag), 1);
      lsr();
      chk("R11 hold ovr clr", int'(overrun_flag), 0);
      pop(v);
      chk("R9 read", v, 8'h5A);
      chk("R9 dr clr", int'(data_ready), 0);

      // R10 break in holding mode
      brk();
      chk("R10 hold dr", int'(data_ready), 1);
      chk("R10 hold brk", int'(break_flag), 1);
      chk("R10 hold zero", int'(rd_data), 0);
      lsr();
      chk("R10 lsr clears brk", int'(break_flag), 0);
      chk("R10 dr stays", int'(data_ready), 1);
      brk();
      pop(v);
      chk("R9 read clears brk", int'(break_flag), 0);
      chk("R9 read clears dr", int'(data_ready), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule